// File: doc/BRIEF.md
# Hardware Cursor Overlay Mixer

This block draws a 64x64 two-plane monochrome cursor over a stream of 32-bit pixels on their way to the display. The scan-out engine presents one pixel per cycle together with its column, and it announces each new scan row with a one-cycle load pulse during horizontal blanking. On that pulse the block decides whether the row crosses the cursor. If it does, the block reads the 16 mask bytes of the matching cursor line from cursor image memory into a line buffer, one byte per cycle.

While the row is scanned, every pixel inside the cursor window is decoded from its AND bit and its XOR bit. The outcome is one of four: cursor colour 0, cursor colour 1, the screen pixel unchanged, or the screen pixel inverted. Cursor pixels at or past the horizontal display width are dropped, so the cursor never wraps onto the next line. Rows past the last visible row are never drawn. Position and image base sit behind a lock flag, so software can change both without a torn frame.

Top module: `cursor_overlay_mixer`

## Requirements
- R1: `pix_o` and `pix_valid_o` follow `pix_i` and `pix_valid_i` with exactly one clock of latency. After reset, both outputs and `mem_rd_o` are 0.
- R2: On a load pulse for a row that crosses the cursor, the block issues 16 reads on consecutive cycles. The addresses are base + line*16 + k, for k = 0 to 15 in ascending order, where line = row - Y. The base is the written base with bits [3:0] forced to 0. Read data is taken one cycle after its address.
- R3: Bytes 0 to 7 of a cursor line are the AND plane and bytes 8 to 15 are the XOR plane. Byte j covers cursor columns 8j to 8j+7, and bit 7 of the byte is the leftmost of those columns.
- R4: AND=0 with XOR=0 outputs {8'hFF, colour0}.
- R5: AND=0 with XOR=1 outputs {8'hFF, colour1}.
- R6: AND=1 with XOR=0 passes the screen pixel through unchanged.
- R7: AND=1 with XOR=1 outputs the bitwise complement of the screen pixel.
- R8: The position word holds X in bits [31:16] and Y in bits [15:0]. The cursor is drawn only where the row lies in Y to Y+63 and the column lies in X to X+63. A row outside that range causes no memory reads.
- R9: While `cur_en_i` is 0, every pixel passes through unchanged. The enable acts on the pixel presented in the same cycle, so clearing it partway through a line takes effect at once.
- R10: A cursor pixel whose column is at or beyond `h_width_i` is suppressed and the screen pixel passes through. Every later cursor pixel on that line is suppressed too.
- R11: A row greater than `v_end_i` is never drawn and causes no memory reads.
- R12: Writing the base word with bit 31 set raises the lock. While the lock is set, new position and base values are held pending and are not used. Writing the base word with bit 31 clear drops the lock, and the pending position and base take effect within two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pos_wr_i | input | 1 | Write strobe for the position word |
| pos_data_i | input | 32 | Position word: X in [31:16], Y in [15:0] |
| base_wr_i | input | 1 | Write strobe for the base word |
| base_data_i | input | 32 | Base word: bit 31 is the lock, [ADDR_W-1:4] is the image base |
| cur_en_i | input | 1 | Cursor enable |
| color0_i | input | 24 | Cursor colour 0 |
| color1_i | input | 24 | Cursor colour 1 |
| h_width_i | input | 16 | Horizontal display width in pixels |
| v_end_i | input | 16 | Last visible row |
| line_load_i | input | 1 | One-cycle pulse that loads the row given on row_i |
| row_i | input | 16 | Current scan row |
| pix_valid_i | input | 1 | Input pixel valid |
| col_i | input | 16 | Column of the input pixel |
| pix_i | input | 32 | Screen pixel |
| mem_rd_o | output | 1 | Cursor memory read request |
| mem_addr_o | output | ADDR_W | Cursor memory byte address |
| mem_data_i | input | 8 | Cursor memory read data, one cycle after the address |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_o | output | 32 | Mixed pixel |

## Verification
The stimulus starts with a directed cursor line whose first eight columns step through colour 0, colour 1, pass-through and inversion. Random mask memory then covers the same four outcomes at random positions within random rows. Rows just above, just below and past the vertical end show whether the row window and the vertical stop are told apart: those rows must draw nothing and fetch nothing. A cursor placed across the right edge checks that clipping cuts the line rather than wrapping it. Clearing the enable mid-line and holding a position change under the lock check that disabling and locking each act on their own.

// File: rtl/cursor_ovl_pkg.sv
// Shared constants, mix outcome type and mask decode for the cursor overlay.
// Assumes a 64x64 cursor stored as 16 bytes per line: AND plane, then XOR plane.
package cursor_ovl_pkg;
    localparam int CUR_SIZE   = 64;
    localparam int LINE_BYTES = 16;
    localparam int PLANE_BYTES = LINE_BYTES / 2;
    localparam int BUF_W      = LINE_BYTES * 8;
    localparam int PIX_W      = 32;
    localparam int COORD_W    = 16;
    localparam int COLOR_W    = 24;
    localparam int LINE_W     = $clog2(CUR_SIZE);
    localparam int BIDX_W     = $clog2(BUF_W);

    typedef enum logic [1:0] {
        MIX_COLOR0 = 2'd0,
        MIX_COLOR1 = 2'd1,
        MIX_PASS   = 2'd2,
        MIX_INVERT = 2'd3
    } mix_op_e;

    // Map one AND bit and one XOR bit to the drawing outcome.
    function automatic mix_op_e decode_masks(input logic and_bit, input logic xor_bit);
        case ({and_bit, xor_bit})
            2'b00:   return MIX_COLOR0;
            2'b01:   return MIX_COLOR1;
            2'b10:   return MIX_PASS;
            default: return MIX_INVERT;
        endcase
    endfunction
endpackage

// File: rtl/cursor_regs.sv
// Position and base registers with a lock. Writes always land in pending copies.
// The active copies follow the pending ones on every cycle the lock is clear.
// Assumes the caller has already aligned the base to a 16-byte line.
module cursor_regs
    import cursor_ovl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pos_wr_i,
    input  logic [31:0]        pos_data_i,
    input  logic               base_wr_i,
    input  logic [ADDR_W-1:0]  base_addr_i,
    input  logic               lock_i,
    output logic [COORD_W-1:0] pos_x_o,
    output logic [COORD_W-1:0] pos_y_o,
    output logic [ADDR_W-1:0]  base_o,
    output logic               locked_o
);
    logic [COORD_W-1:0] pend_x, pend_y;
    logic [ADDR_W-1:0]  pend_base;

    // Capture writes into the pending copies and the lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_x    <= '0;
            pend_y    <= '0;
            pend_base <= '0;
            locked_o  <= 1'b0;
        end else begin
            if (pos_wr_i) begin
                pend_x <= pos_data_i[31:16];
                pend_y <= pos_data_i[15:0];
            end
            if (base_wr_i) begin
                pend_base <= base_addr_i;
                locked_o  <= lock_i;
            end
        end
    end

    // Copy the pending values into the active set while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_x_o <= '0;
            pos_y_o <= '0;
            base_o  <= '0;
        end else if (!locked_o) begin
            pos_x_o <= pend_x;
            pos_y_o <= pend_y;
            base_o  <= pend_base;
        end
    end

    p_lock_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> ($stable(pos_x_o) && $stable(pos_y_o) && $stable(base_o)))
        else $error("active cursor registers changed while locked");
endmodule

// File: rtl/cursor_line_fetch.sv
// Decides on each row-load pulse whether the row crosses the cursor. On a hit it
// reads the 16 mask bytes of that cursor line into a line buffer, one per cycle.
// Assumes memory returns data one cycle after the address, and that the scan
// does not start until the fetch has finished.
module cursor_line_fetch
    import cursor_ovl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_load_i,
    input  logic [COORD_W-1:0] row_i,
    input  logic [COORD_W-1:0] pos_y_i,
    input  logic [COORD_W-1:0] v_end_i,
    input  logic [ADDR_W-1:0]  base_i,
    output logic               mem_rd_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    input  logic [7:0]         mem_data_i,
    output logic [BUF_W-1:0]   line_buf_o,
    output logic               row_hit_o
);
    localparam int CNT_W = $clog2(LINE_BYTES);
    localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(LINE_BYTES - 1);

    logic [COORD_W:0]  row_diff;
    logic              hit;
    logic              busy;
    logic [CNT_W-1:0]  cnt, cnt_q;
    logic              rd_q;
    logic [LINE_W-1:0] line_idx;

    // Row window and vertical end test for the row being loaded.
    always_comb begin
        row_diff = {1'b0, row_i} - {1'b0, pos_y_i};
        hit = (row_i >= pos_y_i) && (row_diff < (COORD_W+1)'(CUR_SIZE)) && (row_i <= v_end_i);
    end

    // Start a fetch on a hit and step the byte counter until the line is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnt       <= '0;
            line_idx  <= '0;
            row_hit_o <= 1'b0;
        end else if (line_load_i) begin
            busy      <= hit;
            cnt       <= '0;
            line_idx  <= row_diff[LINE_W-1:0];
            row_hit_o <= hit;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BYTE) busy <= 1'b0;
        end
    end

    // Store each returned byte in its slot of the line buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q       <= 1'b0;
            cnt_q      <= '0;
            line_buf_o <= '0;
        end else begin
            rd_q  <= busy;
            cnt_q <= cnt;
            if (rd_q) line_buf_o[cnt_q*8 +: 8] <= mem_data_i;
        end
    end

    assign mem_rd_o   = busy;
    assign mem_addr_o = base_i + ADDR_W'({line_idx, 4'b0000}) + ADDR_W'(cnt);

    p_fetch_ascending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && $past(mem_rd_o) && !$past(line_load_i) && $stable(base_i))
            |-> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)))
        else $error("cursor fetch addresses not consecutive");

    p_no_fetch_on_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_load_i && !hit) |=> !mem_rd_o)
        else $error("fetch started for a row outside the cursor");
endmodule

// File: rtl/cursor_pixel_mix.sv
// Per-pixel mixer. It checks the window, enable and right-edge clip, picks the
// AND and XOR bits for the column, and registers the mixed pixel.
// Assumes the line buffer holds the current row's masks before the scan starts.
module cursor_pixel_mix
    import cursor_ovl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_valid_i,
    input  logic [COORD_W-1:0] col_i,
    input  logic [PIX_W-1:0]   pix_i,
    input  logic               cur_en_i,
    input  logic [COORD_W-1:0] pos_x_i,
    input  logic [COORD_W-1:0] h_width_i,
    input  logic               row_hit_i,
    input  logic [BUF_W-1:0]   line_buf_i,
    input  logic [COLOR_W-1:0] color0_i,
    input  logic [COLOR_W-1:0] color1_i,
    output logic               pix_valid_o,
    output logic [PIX_W-1:0]   pix_o
);
    logic [COORD_W:0]  dx;
    logic              in_win;
    logic [BIDX_W-1:0] and_idx, xor_idx;
    mix_op_e           op;
    logic [PIX_W-1:0]  mixed;

    // Work out the window, the bit positions in the line buffer and the outcome.
    always_comb begin
        dx      = {1'b0, col_i} - {1'b0, pos_x_i};
        in_win  = row_hit_i && cur_en_i && (col_i >= pos_x_i) &&
                  (dx < (COORD_W+1)'(CUR_SIZE)) && (col_i < h_width_i);
        and_idx = {1'b0, dx[5:3], ~dx[2:0]};
        xor_idx = {1'b1, dx[5:3], ~dx[2:0]};
        op      = decode_masks(line_buf_i[and_idx], line_buf_i[xor_idx]);
        if (!in_win) begin
            mixed = pix_i;
        end else begin
            case (op)
                MIX_COLOR0: mixed = {8'hFF, color0_i};
                MIX_COLOR1: mixed = {8'hFF, color1_i};
                MIX_PASS:   mixed = pix_i;
                default:    mixed = ~pix_i;
            endcase
        end
    end

    // Output register: one cycle of latency for the pixel and its valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid_o <= 1'b0;
            pix_o       <= '0;
        end else begin
            pix_valid_o <= pix_valid_i;
            pix_o       <= mixed;
        end
    end

    p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid_i |=> pix_valid_o)
        else $error("valid not delayed by one cycle");

    p_disabled_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_en_i |=> (pix_o == $past(pix_i)))
        else $error("pixel changed while cursor disabled");

    p_right_clip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (col_i >= h_width_i) |=> (pix_o == $past(pix_i)))
        else $error("cursor drawn beyond display width");
endmodule

// File: rtl/cursor_overlay_mixer.sv
// Top of the cursor overlay. It ties the locked register set, the line fetch
// into the mask buffer and the per-pixel mixer together.
// Assumes a row-load pulse during horizontal blanking, at least 17 cycles
// before the first pixel of that row.
module cursor_overlay_mixer
    import cursor_ovl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pos_wr_i,
    input  logic [31:0]       pos_data_i,
    input  logic              base_wr_i,
    input  logic [31:0]       base_data_i,
    input  logic              cur_en_i,
    input  logic [23:0]       color0_i,
    input  logic [23:0]       color1_i,
    input  logic [15:0]       h_width_i,
    input  logic [15:0]       v_end_i,
    input  logic              line_load_i,
    input  logic [15:0]       row_i,
    input  logic              pix_valid_i,
    input  logic [15:0]       col_i,
    input  logic [31:0]       pix_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_data_i,
    output logic              pix_valid_o,
    output logic [31:0]       pix_o
);
    logic [COORD_W-1:0] pos_x, pos_y;
    logic [ADDR_W-1:0]  base;
    logic               locked;
    logic [BUF_W-1:0]   line_buf;
    logic               row_hit;
    logic               unused_base_bits;

    assign unused_base_bits = ^{base_data_i[30:ADDR_W], base_data_i[3:0], locked};

    cursor_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pos_wr_i    (pos_wr_i),
        .pos_data_i  (pos_data_i),
        .base_wr_i   (base_wr_i),
        .base_addr_i ({base_data_i[ADDR_W-1:4], 4'b0000}),
        .lock_i      (base_data_i[31]),
        .pos_x_o     (pos_x),
        .pos_y_o     (pos_y),
        .base_o      (base),
        .locked_o    (locked)
    );

    cursor_line_fetch #(.ADDR_W(ADDR_W)) fetch_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_load_i (line_load_i),
        .row_i       (row_i),
        .pos_y_i     (pos_y),
        .v_end_i     (v_end_i),
        .base_i      (base),
        .mem_rd_o    (mem_rd_o),
        .mem_addr_o  (mem_addr_o),
        .mem_data_i  (mem_data_i),
        .line_buf_o  (line_buf),
        .row_hit_o   (row_hit)
    );

    cursor_pixel_mix mix_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid_i (pix_valid_i),
        .col_i       (col_i),
        .pix_i       (pix_i),
        .cur_en_i    (cur_en_i),
        .pos_x_i     (pos_x),
        .h_width_i   (h_width_i),
        .row_hit_i   (row_hit),
        .line_buf_i  (line_buf),
        .color0_i    (color0_i),
        .color1_i    (color1_i),
        .pix_valid_o (pix_valid_o),
        .pix_o       (pix_o)
    );
endmodule

// File: tb/cursor_overlay_mixer_tb.sv
// Self-checking bench: a random mask memory with a fixed seed, plus directed
// corner cases, checked against a bench model of the requirements.
module cursor_overlay_mixer_tb_top;
    localparam int ADDR_W = 12;
    localparam int MEM_N  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pos_wr_i = 1'b0, base_wr_i = 1'b0;
    logic [31:0] pos_data_i = '0, base_data_i = '0;
    logic cur_en_i = 1'b0;
    logic [23:0] color0_i = '0, color1_i = '0;
    logic [15:0] h_width_i = '0, v_end_i = '0;
    logic line_load_i = 1'b0;
    logic [15:0] row_i = '0;
    logic pix_valid_i = 1'b0;
    logic [15:0] col_i = '0;
    logic [31:0] pix_i = '0;
    logic mem_rd_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [7:0] mem_data_i = '0;
    logic pix_valid_o;
    logic [31:0] pix_o;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    logic [7:0] mem [0:MEM_N-1];
    int addr_log [0:255];
    int log_n = 0;

    int m_x = 0, m_y = 0, m_base = 0, pend_x = 0, pend_y = 0;
    bit m_lock = 1'b0, m_en = 1'b0;
    int m_hw = 0, m_vend = 0;

    always #5 clk = ~clk;

    cursor_overlay_mixer #(.ADDR_W(ADDR_W)) dut_i (.*);

    // Memory model with one cycle read latency, and a log of the addresses read.
    always @(posedge clk) begin
        if (mem_rd_o) begin
            mem_data_i <= mem[mem_addr_o];
            addr_log[log_n % 256] <= int'(mem_addr_o);
            log_n <= log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit row_hits(input int row);
        return (row >= m_y) && (row < m_y + 64) && (row <= m_vend);
    endfunction

    function automatic int mask_bit(input int row, input int col, input int plane);
        int line = row - m_y;
        int dx = col - m_x;
        int a = (m_base + line * 16 + plane * 8 + dx / 8) % MEM_N;
        return int'(mem[a][7 - (dx % 8)]);
    endfunction

    function automatic bit in_window(input int row, input int col);
        return m_en && row_hits(row) && col >= m_x && col < m_x + 64 && col < m_hw;
    endfunction

    function automatic logic [31:0] exp_pix(input int row, input int col, input logic [31:0] p);
        if (!in_window(row, col)) return p;
        case ({mask_bit(row, col, 0) != 0, mask_bit(row, col, 1) != 0})
            2'b00:   return {8'hFF, color0_i};
            2'b01:   return {8'hFF, color1_i};
            2'b10:   return p;
            default: return ~p;
        endcase
    endfunction

    function automatic string tag_of(input int row, input int col);
        if (!m_en) return "R9 disabled";
        if (row > m_vend) return "R11 vertical end";
        if (!row_hits(row)) return "R8 row window";
        if (col >= m_x && col < m_x + 64 && col >= m_hw) return "R10 right clip";
        if (!(col >= m_x && col < m_x + 64)) return "R8 column window";
        case ({mask_bit(row, col, 0) != 0, mask_bit(row, col, 1) != 0})
            2'b00:   return "R3,R4 colour0";
            2'b01:   return "R3,R5 colour1";
            2'b10:   return "R3,R6 transparent";
            default: return "R3,R7 invert";
        endcase
    endfunction

    task automatic set_pos(input int x, input int y);
        pos_data_i = {x[15:0], y[15:0]};
        pos_wr_i = 1'b1;
        @(negedge clk);
        pos_wr_i = 1'b0;
        repeat (3) @(negedge clk);
        pend_x = x;
        pend_y = y;
        if (!m_lock) begin
            m_x = x;
            m_y = y;
        end
    endtask

    task automatic set_base(input logic [31:0] d);
        base_data_i = d;
        base_wr_i = 1'b1;
        @(negedge clk);
        base_wr_i = 1'b0;
        repeat (3) @(negedge clk);
        m_lock = d[31];
        if (!d[31]) begin
            m_base = int'(d[ADDR_W-1:0]) & ~15;
            m_x = pend_x;
            m_y = pend_y;
        end
    endtask

    // Pulse the row load, wait out the fetch, then check the read addresses (R2).
    task automatic load_line(input int row);
        int start = log_n;
        row_i = 16'(row);
        line_load_i = 1'b1;
        @(negedge clk);
        line_load_i = 1'b0;
        repeat (20) @(negedge clk);
        if (row_hits(row)) begin
            chk(log_n - start == 16, "R2 read count", 32'(log_n - start), 32'd16);
            for (int k = 0; k < 16 && k < log_n - start; k++)
                chk(addr_log[(start + k) % 256] == (m_base + (row - m_y) * 16 + k) % MEM_N,
                    "R2 read address", 32'(addr_log[(start + k) % 256]),
                    32'((m_base + (row - m_y) * 16 + k) % MEM_N));
        end else begin
            chk(log_n == start, "R8/R11 no fetch on miss", 32'(log_n - start), 32'd0);
        end
    endtask

    // Scan columns 0..ncols-1 of a row; optionally clear the enable at off_col.
    task automatic scan(input int row, input int ncols, input int off_col);
        for (int c = 0; c < ncols; c++) begin
            logic [31:0] p, e;
            logic v;
            string t;
            if (c == off_col) begin
                cur_en_i = 1'b0;
                m_en = 1'b0;
            end
            p = $urandom;
            v = ($urandom % 4) != 0;
            col_i = 16'(c);
            pix_i = p;
            pix_valid_i = v;
            e = exp_pix(row, c, p);
            t = tag_of(row, c);
            @(negedge clk);
            chk(pix_o == e, t, pix_o, e);
            chk(pix_valid_o == v, "R1 valid latency", 32'(pix_valid_o), 32'(v));
        end
        pix_valid_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        for (int i = 0; i < MEM_N; i++) mem[i] = 8'($urandom);
        repeat (4) @(negedge clk);
        chk(pix_valid_o == 1'b0 && pix_o == '0, "R1 reset outputs", pix_o, 32'd0);
        chk(mem_rd_o == 1'b0, "R1 reset no read", 32'(mem_rd_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        color0_i = 24'h123456;
        color1_i = 24'hABCDEF;
        h_width_i = 16'd120;
        m_hw = 120;
        v_end_i = 16'd200;
        m_vend = 200;
        cur_en_i = 1'b1;
        m_en = 1'b1;
        set_base(32'h0000_0305);
        set_pos(10, 5);

        // Directed line 0: first byte pair gives col0,col0,col1,col1,pass,pass,inv,inv.
        mem[12'h300] = 8'h0F;
        mem[12'h308] = 8'h33;
        load_line(5);
        scan(5, 130, -1);

        // Random rows inside, and rows just outside, the window.
        for (int i = 0; i < 6; i++) begin
            int r = 5 + int'($urandom % 64);
            load_line(r);
            scan(r, 130, -1);
        end
        load_line(4);
        scan(4, 130, -1);
        load_line(69);
        scan(69, 130, -1);
        load_line(68);
        scan(68, 130, -1);

        // Right-edge clip.
        set_pos(90, 5);
        load_line(10);
        scan(10, 160, -1);

        // Enable cleared mid-line, then restored.
        set_pos(20, 5);
        load_line(7);
        scan(7, 130, 40);
        cur_en_i = 1'b1;
        m_en = 1'b1;
        load_line(8);
        scan(8, 130, -1);

        // Vertical end.
        v_end_i = 16'd8;
        m_vend = 8;
        load_line(9);
        scan(9, 130, -1);
        load_line(8);
        scan(8, 130, -1);
        v_end_i = 16'd200;
        m_vend = 200;

        // Lock: position and base held until unlocked.
        set_base(32'h8000_0700);
        set_pos(50, 30);
        load_line(10);
        scan(10, 130, -1);
        set_base(32'h0000_0500);
        load_line(35);
        scan(35, 130, -1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule